// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Detector

This block runs the initialise phase of a single-wire, open-drain bus master. A one-cycle start request makes it pull the shared line low for the reset period and then let go. After release it takes a single sample of the line at a fixed instant, inside the window where an attached device answers by pulling the line low. It then keeps the line released until the full recovery period has elapsed.

It reports the outcome on plain control pins. A presence flag is set when the sampled level was low. A one-cycle done pulse marks the end of recovery, and a busy level spans the whole sequence. The block only ever drives the line low, through an active-high drive-low output that feeds an external open-drain pad. The line's return to high comes from the pull-up. All timing is expressed in microseconds and scaled by a clock-cycles-per-microsecond parameter. The block moves no data stream, so it has no valid/ready interface. Start, busy, done and presence are level or pulse signals with no back-pressure.

Top module: `ow_reset_presence`

## Requirements
- R1: A start pulse seen while idle makes `drive_low_o` and `busy_o` high from the next cycle. `drive_low_o` then stays high for exactly LOW_US*CYC_PER_US cycles (default 480 us).
- R2: The block never drives the line high. Once `drive_low_o` falls it stays low until the next accepted start.
- R3: The line is sampled once, at the clock edge that ends the SAMPLE_US*CYC_PER_US-th cycle after release (default 64 us). The sample is taken through a two-flop synchroniser. A sampled 0 sets `present_o` to 1.
- R4: If the line is high at the sampling instant, `present_o` is 0. This covers no device, a device pulse that ends too early, and one that starts too late.
- R5: The released phase lasts exactly (SAMPLE_US+REC_US)*CYC_PER_US cycles (default 64+416 us). `busy_o` then falls.
- R6: `done_o` is high for exactly one cycle: the first idle cycle after recovery, with `busy_o` low.
- R7: `present_o` holds its value while idle. It is cleared in the cycle after a start is accepted.
- R8: A start pulse that arrives while `busy_o` is high has no effect. The low phase length, the released phase length and the single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a reset/presence sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at end of recovery |
| present_o | output | 1 | A device answered (valid after done, held until next start) |
| drive_low_o | output | 1 | 1 = pull the bus line low; 0 = release (open drain) |
| line_i | input | 1 | Level of the bus line (asynchronous) |

## Verification
The assertions check the following on every cycle:
- an accepted start raises the drive and busy at once and clears the presence flag;
- done is a single cycle that ends busy;
- a release is never followed by re-driving the line within the same sequence;
- the presence flag cannot change while idle;
- the phase timer never wraps.

The exact lengths of the low and released phases, and the sampling instant, are parameter-scaled cycle counts. Only the bench's scenarios show them, by counting cycles and by placing modelled device pulses before, across and after the sample point. The same applies to a start issued mid-sequence having no effect.

// File: rtl/ow_rst_pkg.sv
package ow_rst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_REC  = 2'd3
  } ow_phase_t;

  function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned cpu);
    return us * cpu;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= IDLE_LVL;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_LVL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ow_phase_timer.sv
module ow_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o); // R5
endmodule

// File: rtl/ow_rst_ctrl.sv
module ow_rst_ctrl
  import ow_rst_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LOW_CYC  = 1920,
  parameter int unsigned WAIT_CYC = 256,
  parameter int unsigned REC_CYC  = 1664
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tmr_zero_i,
  input  logic             line_s_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             present_o,
  output logic             drive_low_o
);
  localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

  ow_phase_t phase_q, phase_d;
  logic      done_q, done_d;
  logic      pres_q, pres_d;
  logic      accept;

  assign accept = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    phase_d    = phase_q;
    done_d     = 1'b0;
    pres_d     = pres_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d    = PH_LOW;
        pres_d     = 1'b0;
        tmr_load_o = 1'b1;
        tmr_val_o  = LOW_LD;
      end
      PH_LOW: if (tmr_zero_i) begin
        phase_d    = PH_WAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = WAIT_LD;
      end
      PH_WAIT: if (tmr_zero_i) begin
        phase_d    = PH_REC;
        pres_d     = ~line_s_i;
        tmr_load_o = 1'b1;
        tmr_val_o  = REC_LD;
      end
      PH_REC: if (tmr_zero_i) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      pres_q  <= pres_d;
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign present_o   = pres_q;
  assign drive_low_o = (phase_q == PH_LOW);

  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (drive_low_o && busy_o)); // R1
  AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !drive_low_o) |=> !drive_low_o); // R2
  AST_PRES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !present_o); // R7
  AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(present_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R6
  AST_BUSY_START_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !tmr_zero_i) |=> (busy_o && $stable(drive_low_o))); // R8
endmodule

// File: rtl/ow_reset_presence.sv
module ow_reset_presence
  import ow_rst_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned LOW_US     = 480,
  parameter int unsigned SAMPLE_US  = 64,
  parameter int unsigned REC_US     = 416,
  parameter int unsigned SYNC_FF    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic present_o,
  output logic drive_low_o,
  input  logic line_i
);
  localparam int unsigned LOW_CYC  = us_to_cyc(LOW_US, CYC_PER_US);
  localparam int unsigned WAIT_CYC = us_to_cyc(SAMPLE_US, CYC_PER_US);
  localparam int unsigned REC_CYC  = us_to_cyc(REC_US, CYC_PER_US);
  localparam int unsigned MAX_CYC  = max3(LOW_CYC, WAIT_CYC, REC_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             line_s;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  ow_line_sync #(.STAGES(SYNC_FF), .IDLE_LVL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_i),
    .sync_o  (line_s)
  );

  ow_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  ow_rst_ctrl #(
    .CNT_W    (CNT_W),
    .LOW_CYC  (LOW_CYC),
    .WAIT_CYC (WAIT_CYC),
    .REC_CYC  (REC_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tmr_zero_i  (tmr_zero),
    .line_s_i    (line_s),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .present_o   (present_o),
    .drive_low_o (drive_low_o)
  );
endmodule

// File: tb/tb_ow_reset_presence.sv
module tb_ow_reset_presence;
  localparam int CPU      = 4;
  localparam int LOW_EXP  = 480 * CPU;
  localparam int REL_EXP  = (64 + 416) * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, present_o, drive_low_o;
  logic dev_low = 1'b0;
  logic line_i;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bit dev_en = 0;
  int dev_dly = 0;
  int dev_w = 0;

  always #5 clk = ~clk;

  assign line_i = !(drive_low_o || dev_low);

  ow_reset_presence #(.CYC_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .present_o(present_o), .drive_low_o(drive_low_o),
    .line_i(line_i)
  );

  // device model: answers after the master releases the line
  always begin
    @(negedge drive_low_o);
    if (dev_en) begin
      repeat (dev_dly) @(posedge clk);
      dev_low <= 1'b1;
      repeat (dev_w) @(posedge clk);
      dev_low <= 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // run one sequence; optionally pulse start again during low phase
  task automatic run_seq(input string tag, input bit extra_start, input int exp_pres);
    int low_cnt = 0;
    int rel_cnt = 0;
    int redrive = 0;
    int dones = 0;
    bit seen_done = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R1 drive after start"}, drive_low_o, 1);
    check({tag, " R1 busy after start"}, busy_o, 1);
    check({tag, " R7 presence cleared"}, present_o, 0);
    for (int i = 0; i < 3 * LOW_EXP && !seen_done; i++) begin
      if (done_o) begin
        seen_done = 1;
        dones++;
        check({tag, " R6 busy low with done"}, busy_o, 0);
      end else if (drive_low_o) begin
        if (rel_cnt != 0) redrive++;
        low_cnt++;
      end else if (busy_o) rel_cnt++;
      if (extra_start && low_cnt == 100) start_i = 1'b1;
      else start_i = 1'b0;
      if (!seen_done) @(negedge clk);
    end
    start_i = 1'b0;
    check({tag, " R1 low length"}, low_cnt, LOW_EXP);
    check({tag, " R5 released length"}, rel_cnt, REL_EXP);
    check({tag, " R2 no redrive"}, redrive, 0);
    check({tag, " R6 done seen"}, dones, 1);
    check({tag, exp_pres ? " R3 present" : " R4 absent"}, present_o, exp_pres);
    @(negedge clk);
    check({tag, " R6 done one cycle"}, done_o, 0);
    repeat (50) @(negedge clk);
    check({tag, " R7 presence held"}, present_o, exp_pres);
    check({tag, " R6 idle"}, busy_o, 0);
  endtask

  task automatic t_reset_state();
    check("R6 reset busy", busy_o, 0);
    check("R6 reset done", done_o, 0);
    check("R7 reset present", present_o, 0);
    check("R2 reset drive", drive_low_o, 0);
  endtask

  task automatic t_device(input string tag, input int dly_us, input int w_us, input int exp);
    dev_en = 1; dev_dly = dly_us * CPU; dev_w = w_us * CPU;
    run_seq(tag, 0, exp);
  endtask

  task automatic t_no_device();
    dev_en = 0;
    run_seq("nodev", 0, 0);
  endtask

  task automatic t_busy_start();
    dev_en = 1; dev_dly = 30 * CPU; dev_w = 120 * CPU;
    run_seq("r8_busy_start", 1, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_device("early_edge", 15, 60, 1);
    t_no_device();
    t_device("late_edge", 60, 240, 1);
    t_device("short_pulse", 15, 30, 0);
    t_device("too_late", 70, 120, 0);
    t_busy_start();
    t_no_device();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule